// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block carries out one complete NAND bus transaction each time software writes a control word with its start flag set. A single transaction can have up to five parts, always in this order:

- a first command byte, sent with CLE high;
- a number of address bytes, sent with ALE high;
- up to four programmed-I/O data bytes, either sent to or read from the device;
- an optional second command byte, such as a read or erase confirm;
- an optional wait until the device's ready/busy line reports ready.

Each part has its own enable flag in the control word. A part whose flag is clear is skipped. Byte counts are stored as the count minus one.

Software loads two command registers, two address registers and a 32-bit data register, then writes the control word. It then waits for the one-cycle `done` pulse. Every byte strobe has a fixed length. There is no ECC, DMA, page buffer or programmable timing.

Top module: `nand_cmd_seq`

## Requirements
- R1: Writing the control register with bit 31 set starts a transaction. Bit 31 reads back as 1 while the transaction runs. It clears in the same cycle that `done` rises, and `done` is high for exactly one cycle per transaction.
- R2: Parts run in this fixed order: first command, address, data, second command, ready wait. The enables are bit 30 (first command), bit 29 (address), bit 28 (data), bit 25 (second command) and bit 16 (ready wait). A part whose enable is clear produces no strobe. CLE and ALE are never high together.
- R3: The first command part sends bits 7:0 of register 1 with CLE high and ALE low.
- R4: The address part sends bits 3:0 of the control word plus one bytes, with ALE high. Byte k (counting from 0) is byte k of the 64-bit value {register 4, register 3}, taken from the least significant byte upward. Bytes with k of 8 or more are sent as 0x00.
- R5: In a data part with bit 26 clear, the block writes bits 23:20 plus one bytes, capped at four. Byte k is bits 8k+7:8k of register 5.
- R6: In a data part with bit 26 set, the block reads the same number of bytes instead; bit 26 takes precedence over bit 27. Read byte k is stored into bits 8k+7:8k of register 5, and the other bytes of register 5 keep their values. The data bus output enable is low during reads.
- R7: The second command part sends bits 7:0 of register 2 with CLE high.
- R8: Each byte drives WE# (for writes) or RE# (for reads) low for exactly 2 clocks. Between two strobes of one transaction the line stays high for at least 2 clocks. Read data is captured on the clock edge where RE# rises.
- R9: While a transaction runs, chip-enable pin n is low exactly when control bit 8+n is set. While idle, all chip enables are high.
- R10: With bit 16 set, `done` rises exactly two clocks after the ready/busy input goes high, which allows for one synchronizer stage. With bit 16 clear, the ready/busy input is ignored.
- R11: Software writes to any register while a transaction runs are ignored. The running transaction and the stored values are unchanged.
- R12: After reset all chip enables, WE# and RE# are high, CLE, ALE, the output enable and `done` are low, and every register reads 0.
- R13: Register indices are: 0 control, 1 first command, 2 second command, 3 address low, 4 address high, 5 data. Index 6 and index 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data (combinational) |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | NUM_CE | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input |
| nand_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
The bench builds the block with its defaults: eight chip enables and a 2-low/2-high strobe. This means every chip-select bit position can be exercised, and the exact strobe widths can be checked against fixed numbers.

The vectors cover:
- address counts of 1, 3, 5 and 10 bytes, which reaches the zero-fill beyond the eight stored address bytes;
- data counts of 1, 2 and 4 bytes, plus an over-range count that is capped at four;
- both directions, including a word with both direction flags set;
- an empty transaction and a transaction that only waits for ready.

The bench releases ready/busy at a known cycle, which pins down the two-cycle latency to `done`.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  // control word flag positions
  localparam int CW_GO   = 31;
  localparam int CW_CMD  = 30;
  localparam int CW_ADR  = 29;
  localparam int CW_PIO  = 28;
  localparam int CW_TX   = 27;
  localparam int CW_RX   = 26;
  localparam int CW_CMD2 = 25;
  localparam int CW_RDY  = 16;
  localparam int CW_DLEN_LSB = 20;
  localparam int CW_CE_LSB   = 8;
  localparam int CW_ALEN_LSB = 0;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;

  // register indices
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_CMDA = 3'd1;
  localparam logic [2:0] IDX_CMDB = 3'd2;
  localparam logic [2:0] IDX_ADRL = 3'd3;
  localparam logic [2:0] IDX_ADRH = 3'd4;
  localparam logic [2:0] IDX_DATA = 3'd5;

  // phase encoding follows the execution order
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD1 = 3'd1,
    PH_ADDR = 3'd2,
    PH_DATA = 3'd3,
    PH_CMD2 = 3'd4,
    PH_WAIT = 3'd5
  } phase_e;
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int PIO_MAX = 4,
  localparam int LANEW = (PIO_MAX > 1) ? $clog2(PIO_MAX) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_idx,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [2:0]          rd_idx,
  output logic [REG_W-1:0]    rd_data,
  input  logic                clr_go,
  input  logic                cap_en,
  input  logic [LANEW-1:0]    cap_lane,
  input  logic [BYTE_W-1:0]   cap_byte,
  output logic [REG_W-1:0]    ctrl,
  output logic [BYTE_W-1:0]   cmd_a,
  output logic [BYTE_W-1:0]   cmd_b,
  output logic [REG_W-1:0]    adr_lo,
  output logic [REG_W-1:0]    adr_hi,
  output logic [REG_W-1:0]    pio_word
);
  logic [REG_W-1:0]  ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] cmda_q, cmda_d, cmdb_q, cmdb_d;
  logic [REG_W-1:0]  adrl_q, adrl_d, adrh_q, adrh_d;
  logic [REG_W-1:0]  pio_q, pio_d;
  logic              wr_ok;

  // software access only while no transaction runs
  assign wr_ok = wr_en && !ctrl_q[CW_GO];

  always_comb begin
    ctrl_d = ctrl_q;
    cmda_d = cmda_q;
    cmdb_d = cmdb_q;
    adrl_d = adrl_q;
    adrh_d = adrh_q;
    pio_d  = pio_q;
    if (clr_go) begin
      ctrl_d[CW_GO] = 1'b0;
    end else if (wr_ok && wr_idx == IDX_CTRL) begin
      ctrl_d = wr_data;
    end
    if (wr_ok && wr_idx == IDX_CMDA) cmda_d = wr_data[BYTE_W-1:0];
    if (wr_ok && wr_idx == IDX_CMDB) cmdb_d = wr_data[BYTE_W-1:0];
    if (wr_ok && wr_idx == IDX_ADRL) adrl_d = wr_data;
    if (wr_ok && wr_idx == IDX_ADRH) adrh_d = wr_data;
    if (cap_en) begin
      pio_d[{cap_lane, 3'b000} +: BYTE_W] = cap_byte;
    end else if (wr_ok && wr_idx == IDX_DATA) begin
      pio_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmda_q <= '0;
      cmdb_q <= '0;
      adrl_q <= '0;
      adrh_q <= '0;
      pio_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmda_q <= cmda_d;
      cmdb_q <= cmdb_d;
      adrl_q <= adrl_d;
      adrh_q <= adrh_d;
      pio_q  <= pio_d;
    end
  end

  always_comb begin
    case (rd_idx)
      IDX_CTRL: rd_data = ctrl_q;
      IDX_CMDA: rd_data = {{(REG_W-BYTE_W){1'b0}}, cmda_q};
      IDX_CMDB: rd_data = {{(REG_W-BYTE_W){1'b0}}, cmdb_q};
      IDX_ADRL: rd_data = adrl_q;
      IDX_ADRH: rd_data = adrh_q;
      IDX_DATA: rd_data = pio_q;
      default:  rd_data = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign cmd_a    = cmda_q;
  assign cmd_b    = cmdb_q;
  assign adr_lo   = adrl_q;
  assign adr_hi   = adrh_q;
  assign pio_word = pio_q;

  AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[CW_GO]) |-> $stable(adrl_q)) else $error("address changed while busy"); // R11
endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2,
  localparam int TOT  = LOW_CYC + HIGH_CYC,
  localparam int CNTW = $clog2(TOT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_rd,
  output logic active,
  output logic we_n,
  output logic re_n,
  output logic fin,
  output logic sample
);
  logic            act_q, act_d;
  logic            rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            low;

  assign low    = act_q && (cnt_q < CNTW'(LOW_CYC));
  assign fin    = act_q && (cnt_q == CNTW'(TOT - 1));
  // last low cycle of a read: data is taken on the edge that raises RE#
  assign sample = act_q && rd_q && (cnt_q == CNTW'(LOW_CYC - 1));

  always_comb begin
    act_d = act_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (go) begin
      act_d = 1'b1;
      rd_d  = go_rd;
      cnt_d = '0;
    end else if (fin) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
  assign we_n   = !(low && !rd_q);
  assign re_n   = !(low && rd_q);

  generate
    if (LOW_CYC >= 2) begin : g_low_chk
      AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n) else $error("WE# low too short"); // R8
      AST_RE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |=> !re_n) else $error("RE# low too short"); // R8
    end
    if (HIGH_CYC >= 2) begin : g_high_chk
      AST_WE_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |=> we_n) else $error("WE# high too short"); // R8
    end
  endgenerate
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int PIO_MAX = 4,
  localparam int LANEW = (PIO_MAX > 1) ? $clog2(PIO_MAX) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REG_W-1:0]        ctrl,
  input  logic [BYTE_W-1:0]       cmd_a,
  input  logic [BYTE_W-1:0]       cmd_b,
  input  logic [REG_W-1:0]        adr_lo,
  input  logic [REG_W-1:0]        adr_hi,
  input  logic [PIO_MAX*BYTE_W-1:0] pio_word,
  input  logic                    rdy_pin,
  input  logic                    st_fin,
  input  logic                    st_sample,
  output logic                    go,
  output logic                    go_rd,
  output phase_e                  phase,
  output logic [BYTE_W-1:0]       tx_byte,
  output logic                    cap_en,
  output logic [LANEW-1:0]        cap_lane,
  output logic                    clr_go,
  output logic                    done
);
  phase_e          ph_q, ph_d, nxt;
  logic [3:0]      idx_q, idx_d;
  logic            iss_q, iss_d;
  logic            done_q, done_d;
  logic            rdy_s_q;
  logic            fin_seq;
  logic [3:0]      last, dlast;
  logic [2*REG_W-1:0] adr_all;
  logic            unused_bits;

  assign unused_bits = ^{ctrl[24], ctrl[19:17], ctrl[15:4]};
  assign adr_all = {adr_hi, adr_lo};
  assign dlast = (ctrl[CW_DLEN_LSB +: 4] > 4'(PIO_MAX - 1)) ? 4'(PIO_MAX - 1)
                                                           : ctrl[CW_DLEN_LSB +: 4];

  function automatic phase_e pick_next(phase_e cur, logic [REG_W-1:0] cw);
    if (cur < PH_CMD1 && cw[CW_CMD])  return PH_CMD1;
    if (cur < PH_ADDR && cw[CW_ADR])  return PH_ADDR;
    if (cur < PH_DATA && cw[CW_PIO])  return PH_DATA;
    if (cur < PH_CMD2 && cw[CW_CMD2]) return PH_CMD2;
    if (cur < PH_WAIT && cw[CW_RDY])  return PH_WAIT;
    return PH_IDLE;
  endfunction

  always_comb begin
    case (ph_q)
      PH_ADDR: last = ctrl[CW_ALEN_LSB +: 4];
      PH_DATA: last = dlast;
      default: last = 4'd0;
    endcase
  end

  always_comb begin
    ph_d    = ph_q;
    idx_d   = idx_q;
    iss_d   = iss_q;
    fin_seq = 1'b0;
    go      = 1'b0;
    nxt     = pick_next(ph_q, ctrl);
    case (ph_q)
      PH_IDLE: begin
        if (ctrl[CW_GO]) begin
          ph_d  = nxt;
          idx_d = '0;
          iss_d = 1'b0;
          if (nxt == PH_IDLE) fin_seq = 1'b1;
        end
      end
      PH_WAIT: begin
        if (rdy_s_q) begin
          ph_d    = PH_IDLE;
          fin_seq = 1'b1;
        end
      end
      default: begin
        if (!iss_q) begin
          go    = 1'b1;
          iss_d = 1'b1;
        end else if (st_fin) begin
          iss_d = 1'b0;
          if (idx_q == last) begin
            ph_d  = nxt;
            idx_d = '0;
            if (nxt == PH_IDLE) fin_seq = 1'b1;
          end else begin
            idx_d = idx_q + 4'd1;
          end
        end
      end
    endcase
    done_d = fin_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      idx_q   <= '0;
      iss_q   <= 1'b0;
      done_q  <= 1'b0;
      rdy_s_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      iss_q   <= iss_d;
      done_q  <= done_d;
      rdy_s_q <= rdy_pin;
    end
  end

  always_comb begin
    case (ph_q)
      PH_CMD1: tx_byte = cmd_a;
      PH_CMD2: tx_byte = cmd_b;
      PH_ADDR: tx_byte = idx_q[3] ? '0 : adr_all[{idx_q[2:0], 3'b000} +: BYTE_W];
      PH_DATA: tx_byte = pio_word[{idx_q[LANEW-1:0], 3'b000} +: BYTE_W];
      default: tx_byte = '0;
    endcase
  end

  assign go_rd    = (ph_q == PH_DATA) && ctrl[CW_RX];
  assign cap_en   = st_sample && (ph_q == PH_DATA);
  assign cap_lane = idx_q[LANEW-1:0];
  assign clr_go   = fin_seq;
  assign done     = done_q;
  assign phase    = ph_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R1
  AST_WAIT_GATES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT && !rdy_s_q) |=> !done_q) else $error("done while busy"); // R10
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q) && ph_q != PH_IDLE) |-> (ph_q > $past(ph_q)))
    else $error("phase went backwards"); // R2
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_CE   = 8,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [2:0]         reg_wr_idx,
  input  logic [31:0]        reg_wr_data,
  input  logic [2:0]         reg_rd_idx,
  output logic [31:0]        reg_rd_data,
  output logic               done,
  output logic [NUM_CE-1:0]  nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [7:0]         nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [7:0]         nand_dq_in,
  input  logic               nand_rdy
);
  localparam int PIO_MAX = REG_W / BYTE_W;
  localparam int LANEW   = $clog2(PIO_MAX);

  logic [1:0]          rst_pipe;
  logic                rst_s_n;
  logic [REG_W-1:0]    ctrl, adr_lo, adr_hi, pio_word;
  logic [BYTE_W-1:0]   cmd_a, cmd_b, tx_byte;
  logic                clr_go, cap_en, go, go_rd;
  logic [LANEW-1:0]    cap_lane;
  logic                st_act, st_fin, st_sample;
  phase_e              phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  nand_seq_regs #(.PIO_MAX(PIO_MAX)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
    .rd_idx(reg_rd_idx), .rd_data(reg_rd_data),
    .clr_go(clr_go), .cap_en(cap_en), .cap_lane(cap_lane), .cap_byte(nand_dq_in),
    .ctrl(ctrl), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .adr_lo(adr_lo), .adr_hi(adr_hi), .pio_word(pio_word)
  );

  nand_seq_ctrl #(.PIO_MAX(PIO_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n),
    .ctrl(ctrl), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .adr_lo(adr_lo), .adr_hi(adr_hi), .pio_word(pio_word),
    .rdy_pin(nand_rdy), .st_fin(st_fin), .st_sample(st_sample),
    .go(go), .go_rd(go_rd), .phase(phase), .tx_byte(tx_byte),
    .cap_en(cap_en), .cap_lane(cap_lane), .clr_go(clr_go), .done(done)
  );

  nand_seq_strobe #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_s_n),
    .go(go), .go_rd(go_rd),
    .active(st_act), .we_n(nand_we_n), .re_n(nand_re_n),
    .fin(st_fin), .sample(st_sample)
  );

  assign nand_ce_n   = ctrl[CW_GO] ? ~ctrl[CW_CE_LSB +: NUM_CE] : '1;
  assign nand_cle    = st_act && (phase == PH_CMD1 || phase == PH_CMD2);
  assign nand_ale    = st_act && (phase == PH_ADDR);
  assign nand_dq_oe  = st_act && !go_rd;
  assign nand_dq_out = tx_byte;

  AST_GO_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> !ctrl[CW_GO]) else $error("start bit still set at done"); // R1
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_s_n)
    nand_cle |-> !nand_ale) else $error("CLE and ALE together"); // R2
  AST_OE_NOT_READING: assert property (@(posedge clk) disable iff (!rst_s_n)
    nand_dq_oe |-> nand_re_n) else $error("bus driven during read"); // R6
endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
  localparam int NV  = 11;
  localparam int REL = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_idx = '0;
  logic [31:0] reg_rd_data;
  logic        done;
  logic [7:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rdy = 1'b0;

  always #2 clk = ~clk;

  nand_cmd_seq dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .done(done),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
  );

  // {ctrl, cmd_a, cmd_b, adr_lo, adr_hi, data, device byte base}
  localparam logic [151:0] VEC [NV] = '{
    {32'hE2010104, 8'h00, 8'h30, 32'hBEEF0010, 32'h00000003, 32'h00000000, 8'h00},
    {32'hE2010402, 8'h60, 8'hD0, 32'h00A1B2C3, 32'h00000000, 32'h00000000, 8'h00},
    {32'hD4000200, 8'h70, 8'h00, 32'h00000000, 32'h00000000, 32'h11223344, 8'hE0},
    {32'h98308000, 8'h00, 8'h00, 32'h00000000, 32'h00000000, 32'hA1B2C3D4, 8'h00},
    {32'hF4300100, 8'h90, 8'h00, 32'h00000020, 32'h00000000, 32'h00000000, 8'h2C},
    {32'h98900800, 8'h00, 8'h00, 32'h00000000, 32'h00000000, 32'h04030201, 8'h00},
    {32'hA0000109, 8'h00, 8'h00, 32'h44332211, 32'h88776655, 32'h00000000, 8'h00},
    {32'hFA102001, 8'h80, 8'h10, 32'h00005A5A, 32'h00000000, 32'h0000BEEF, 8'h00},
    {32'h9C100100, 8'h00, 8'h00, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 8'h40},
    {32'h80000100, 8'h00, 8'h00, 32'h00000000, 32'h00000000, 32'h00000000, 8'h00},
    {32'h80010100, 8'h00, 8'h00, 32'h00000000, 32'h00000000, 32'h00000000, 8'h00}
  };

  int checks = 0;
  int fails  = 0;
  int gcyc   = 0;

  // bus monitor state
  bit         mon_on = 1'b0;
  int         ev_n, lo_len, hi_len, bad_lo, bad_hi, bad_ce, rd_cnt;
  bit         seen_strobe, prev_we, prev_re;
  logic [2:0] ev_k [64];
  logic [7:0] ev_b [64];
  logic [7:0] ce_exp_n, devbase;

  // expected stream
  int         exp_n;
  logic [2:0] exp_k [64];
  logic [7:0] exp_b [64];
  logic [31:0] exp_data;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_rd_idx = idx;
    #0.5;
    d = reg_rd_data;
  endtask

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<150000", gcyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (!nand_we_n || !nand_re_n) begin
        if (prev_we && prev_re) begin
          if (seen_strobe && hi_len < 2) bad_hi++;
          seen_strobe = 1'b1;
          if (!nand_re_n) nand_dq_in = devbase + 8'(rd_cnt);
        end
        hi_len = 0;
        lo_len++;
        if (nand_ce_n !== ce_exp_n) bad_ce++;
      end else begin
        hi_len++;
        if (!prev_we) begin
          if (lo_len != 2) bad_lo++;
          if (!nand_dq_oe)                 ev_k[ev_n] = 3'd5;
          else if (nand_cle && !nand_ale)  ev_k[ev_n] = 3'd1;
          else if (nand_ale && !nand_cle)  ev_k[ev_n] = 3'd2;
          else if (!nand_ale && !nand_cle) ev_k[ev_n] = 3'd3;
          else                             ev_k[ev_n] = 3'd5;
          ev_b[ev_n] = nand_dq_out;
          if (ev_n < 63) ev_n++;
          lo_len = 0;
        end else if (!prev_re) begin
          if (lo_len != 2) bad_lo++;
          ev_k[ev_n] = (nand_cle || nand_ale || nand_dq_oe) ? 3'd5 : 3'd4;
          ev_b[ev_n] = devbase + 8'(rd_cnt);
          rd_cnt++;
          if (ev_n < 63) ev_n++;
          lo_len = 0;
        end
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  task automatic push(input logic [2:0] k, input logic [7:0] b);
    exp_k[exp_n] = k;
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input logic [31:0] cw, input logic [7:0] ca, input logic [7:0] cb,
                           input logic [31:0] al, input logic [31:0] ah,
                           input logic [31:0] dw, input logic [7:0] db);
    logic [63:0] aa;
    int dn;
    aa = {ah, al};
    exp_n = 0;
    exp_data = dw;
    if (cw[30]) push(3'd1, ca);
    if (cw[29]) begin
      for (int i = 0; i <= int'(cw[3:0]); i++) begin
        if (i < 8) push(3'd2, aa[8*i +: 8]);
        else       push(3'd2, 8'h00);
      end
    end
    if (cw[28]) begin
      dn = (cw[23:20] > 4'd3) ? 4 : int'(cw[23:20]) + 1;
      for (int i = 0; i < dn; i++) begin
        if (cw[26]) begin
          push(3'd4, db + 8'(i));
          exp_data[8*i +: 8] = db + 8'(i);
        end else begin
          push(3'd3, dw[8*i +: 8]);
        end
      end
    end
    if (cw[25]) push(3'd1, cb);
  endtask

  task automatic run_vec(input logic [151:0] v, input bit inject);
    logic [31:0] cw, al, ah, dw, r;
    logic [7:0]  ca, cb, db;
    int cyc, done_cnt, done_at;
    string tag;
    {cw, ca, cb, al, ah, dw, db} = v;
    nand_rdy = 1'b0;
    wr(3'd1, {24'h0, ca});
    wr(3'd2, {24'h0, cb});
    wr(3'd3, al);
    wr(3'd4, ah);
    wr(3'd5, dw);
    build_exp(cw, ca, cb, al, ah, dw, db);
    ce_exp_n = ~cw[15:8];
    devbase = db;
    ev_n = 0; lo_len = 0; hi_len = 0; bad_lo = 0; bad_hi = 0; bad_ce = 0; rd_cnt = 0;
    seen_strobe = 1'b0; prev_we = 1'b1; prev_re = 1'b1;
    mon_on = 1'b1;
    wr(3'd0, cw);
    rd(3'd0, r);
    chk(r[31] == 1'b1, "R1 start bit set while running", r, cw);
    cyc = 0; done_cnt = 0; done_at = -1;
    while (cyc < REL + 40) begin
      @(negedge clk);
      cyc++;
      reg_wr_en = 1'b0;
      if (inject && cyc == 4) begin
        // R11: attempted rewrite of the control word mid-run
        reg_wr_en = 1'b1; reg_wr_idx = 3'd0; reg_wr_data = 32'hC0000400;
      end
      if (cyc == REL) nand_rdy = 1'b1;
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = cyc;
      end
    end
    mon_on = 1'b0;
    chk(done_cnt == 1, "R1 one done pulse", 32'(done_cnt), 32'd1);
    if (cw[16])
      chk(done_at == REL + 2, "R10 done two cycles after ready", 32'(done_at), 32'(REL + 2));
    else
      chk(done_at > 0 && done_at < REL, "R10 ready ignored when wait off", 32'(done_at), 32'(REL));
    rd(3'd0, r);
    chk(r == {1'b0, cw[30:0]}, "R1 R11 control after done", r, {1'b0, cw[30:0]});
    chk(ev_n == exp_n, "R2 strobe count", 32'(ev_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < ev_n; i++) begin
      case (exp_k[i])
        3'd1:    tag = "R3 R7 command byte";
        3'd2:    tag = "R4 address byte";
        3'd3:    tag = "R5 write data byte";
        default: tag = "R6 read data byte";
      endcase
      chk(ev_k[i] == exp_k[i] && ev_b[i] == exp_b[i], tag,
          {21'h0, ev_k[i], ev_b[i]}, {21'h0, exp_k[i], exp_b[i]});
    end
    chk(bad_lo == 0 && bad_hi == 0, "R8 strobe widths", 32'(bad_lo + bad_hi), 32'd0);
    chk(bad_ce == 0, "R9 chip enable during strobes", 32'(bad_ce), 32'd0);
    rd(3'd5, r);
    chk(r == exp_data, "R6 data register", r, exp_data);
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(nand_ce_n == 8'hFF && nand_we_n && nand_re_n, "R12 strobes idle in reset",
        {22'h0, nand_ce_n, nand_we_n, nand_re_n}, {22'h0, 8'hFF, 2'b11});
    chk(!nand_cle && !nand_ale && !nand_dq_oe && !done, "R12 controls low in reset",
        {28'h0, nand_cle, nand_ale, nand_dq_oe, done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), r);
      chk(r == 32'h0, "R12 R13 register zero after reset", r, 32'h0);
    end
    chk(nand_ce_n == 8'hFF, "R9 chip enables high while idle", {24'h0, nand_ce_n}, 32'hFF);

    // main vector table
    for (int n = 0; n < NV; n++) run_vec(VEC[n], 1'b0);

    // R11: control rewrite while busy is ignored
    run_vec(VEC[0], 1'b1);

    // R13: register map readback and unused indices
    wr(3'd3, 32'hCAFE1234);
    rd(3'd3, r);
    chk(r == 32'hCAFE1234, "R13 address low readback", r, 32'hCAFE1234);
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd6, r);
    chk(r == 32'h0, "R13 unused index reads zero", r, 32'h0);
    rd(3'd1, r);
    chk(r == 32'h0, "R13 first command readback", r, 32'h0);
    chk(nand_ce_n == 8'hFF, "R9 chip enables high after runs", {24'h0, nand_ce_n}, 32'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule